// File: doc/BRIEF.md
# Serial Clock Baudrate Reload Timer

This block produces the shift clock of a synchronous serial port from the module clock. A down-counting timer, as wide as the reload value, is preset from a programmable reload value. Each time it reaches zero it presets itself again and flips the serial clock. The serial clock therefore runs at the module clock divided by 2 × (reload + 1). A single-cycle tick marks every half period, so a shifter can use it to move data.

One register address serves two roles, and the enable input decides which. While the port is disabled, the address reads and writes the stored reload value. While the port is enabled, it reads the live timer contents, and writes to it are refused. A master/slave input limits the fastest setting. In slave mode a reload value of zero is clamped to one, and a sticky configuration-error flag is raised. Software clears the flag with any write made while the port is disabled.

Top module: `sclk_reload_timer`

## Requirements
- R1: After reset the stored reload value is 0x0000, `sclk` is low, `half_tick` is low and `cfg_err` is low.
- R2: While `en` is low, a cycle with `reg_wr` high stores `reg_wdata` as the reload value, and `reg_rdata` returns the stored reload value.
- R3: While `en` is high, `reg_rdata` returns the live timer. On the first clock edge with `en` high, the timer is loaded with the effective reload value E. At the edges after that it counts E-1, E-2 and so on, with no idle cycle.
- R4: A write while `en` is high changes neither the stored reload value nor the timer sequence.
- R5: While enabled, `half_tick` is high for exactly one cycle each time the timer is zero. The first tick comes E+1 clock edges after the enabling edge, and each later tick comes E+1 edges after the one before.
- R6: At the clock edge that ends a tick cycle, the timer reloads with E and `sclk` changes level, so one `sclk` period is 2 × (E+1) module clocks.
- R7: While `en` is low, the timer holds, `half_tick` stays low, and `sclk` returns to low at the next edge.
- R8: In master mode (`master_mode` = 1) a reload value of 0 is used as is, which gives one tick every cycle (half the module clock as `sclk`).
- R9: In slave mode (`master_mode` = 0) a stored reload value of 0 gives E = 1 (a quarter of the module clock) and sets `cfg_err`. The flag stays set until a write is made while `en` is low.
- R10: For a 40 MHz module clock, reload 0x0013 gives 40 clocks per `sclk` period (1 Mbit/s), 0x0009 gives 20 (2 Mbit/s) and 0xFFFF gives 131072 (about 305 bit/s).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; starts and stops the timer |
| master_mode | input | 1 | 1 = master, 0 = slave (minimum effective reload 1) |
| reg_wr | input | 1 | Register write strobe, honoured only while disabled |
| reg_wdata | input | 16 | Reload value to store |
| reg_rdata | output | 16 | Reload value when disabled, live timer when enabled |
| sclk | output | 1 | Serial shift clock, low while idle |
| half_tick | output | 1 | One-cycle pulse at each timer underflow |
| cfg_err | output | 1 | Sticky flag: slave mode was run with reload zero |

## Verification
The bench measures the edge count to the first tick and to the next tick after an enable. A design that inserts a start-up cycle, or that reloads with E instead of counting through zero, shows up as an off-by-one there. Reload zero is run in both modes. A missing clamp gives a one-cycle slave period, and a wrong clamp slows master mode. A stray write made while enabled must leave both the readback and the tick gap unchanged, which catches a design that lets the write through to the timer. The sticky flag is checked to survive a disable and then to clear on the next disabled write. The 0xFFFF case exposes a counter that is too narrow or that wraps.

// File: rtl/brt_pkg.sv
package brt_pkg;
   typedef enum logic [1:0] {
      CNT_HOLD   = 2'd0,
      CNT_LOAD   = 2'd1,
      CNT_DEC    = 2'd2,
      CNT_RELOAD = 2'd3
   } cnt_op_e;
endpackage

// File: rtl/brt_reload_reg.sv
module brt_reload_reg #(
   parameter int W           = 16,
   parameter bit SLAVE_CLAMP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         master_mode,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] reload_q,
   output logic [W-1:0] eff_reload,
   output logic         cfg_err
);
   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   logic wr_ok;
   logic slave_zero;

   assign wr_ok      = wr & ~en;
   assign slave_zero = ~master_mode & (reload_q == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= ZERO;
      end else if (wr_ok) begin
         reload_q <= wdata;
      end
   end

   generate
      if (SLAVE_CLAMP) begin : g_clamp
         assign eff_reload = slave_zero ? ONE : reload_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cfg_err <= 1'b0;
            end else if (wr_ok) begin
               cfg_err <= 1'b0;
            end else if (en && slave_zero) begin
               cfg_err <= 1'b1;
            end
         end
      end else begin : g_noclamp
         assign eff_reload = reload_q;
         assign cfg_err    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/brt_ctrl.sv
module brt_ctrl
   import brt_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    en,
   input  logic    cnt_zero,
   output cnt_op_e op,
   output logic    half_tick
);
   logic run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= en;
   end

   always_comb begin
      if (!en)          op = CNT_HOLD;
      else if (!run_q)  op = CNT_LOAD;
      else if (cnt_zero) op = CNT_RELOAD;
      else              op = CNT_DEC;
   end

   assign half_tick = (op == CNT_RELOAD);
endmodule

// File: rtl/brt_counter.sv
module brt_counter
   import brt_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  cnt_op_e      op,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count_q,
   output logic         cnt_zero
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else begin
         unique case (op)
            CNT_LOAD, CNT_RELOAD: count_q <= load_val;
            CNT_DEC:              count_q <= count_q - ONE;
            default:              count_q <= count_q;
         endcase
      end
   end

   assign cnt_zero = (count_q == '0);
endmodule

// File: rtl/brt_sclk.sv
module brt_sclk (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic half_tick,
   output logic sclk
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sclk <= 1'b0;
      else if (!en)       sclk <= 1'b0;
      else if (half_tick) sclk <= ~sclk;
   end
endmodule

// File: rtl/sclk_reload_timer.sv
module sclk_reload_timer
   import brt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter bit SLAVE_CLAMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             master_mode,
   input  logic             reg_wr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   output logic             sclk,
   output logic             half_tick,
   output logic             cfg_err
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("sclk_reload_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] eff_reload;
   logic [CNT_W-1:0] count_q;
   logic             cnt_zero;
   cnt_op_e          op;

   brt_reload_reg #(.W(CNT_W), .SLAVE_CLAMP(SLAVE_CLAMP)) u_reload (
      .clk(clk), .rst_n(rst_n), .en(en), .master_mode(master_mode),
      .wr(reg_wr), .wdata(reg_wdata), .reload_q(reload_q),
      .eff_reload(eff_reload), .cfg_err(cfg_err)
   );

   brt_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .cnt_zero(cnt_zero),
      .op(op), .half_tick(half_tick)
   );

   brt_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .op(op), .load_val(eff_reload),
      .count_q(count_q), .cnt_zero(cnt_zero)
   );

   brt_sclk u_sclk (
      .clk(clk), .rst_n(rst_n), .en(en), .half_tick(half_tick), .sclk(sclk)
   );

   assign reg_rdata = en ? count_q : reload_q;
endmodule

// File: rtl/sclk_reload_timer_chk.sv
module sclk_reload_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             reg_wr,
   input logic [CNT_W-1:0] reload_q,
   input logic             sclk,
   input logic             half_tick,
   input logic             cfg_err
);
   p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> (!sclk && !cfg_err));

   p_no_tick_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !half_tick);

   p_sclk_low_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !sclk);

   p_toggle_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      half_tick |=> (sclk != $past(sclk)));

   p_steady_between_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !half_tick) |=> $stable(sclk));

   p_reload_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(reload_q));

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !(reg_wr && !en)) |=> cfg_err);

   p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !en) |=> !cfg_err);
endmodule

bind sclk_reload_timer sclk_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .reg_wr(reg_wr), .reload_q(reload_q),
   .sclk(sclk), .half_tick(half_tick), .cfg_err(cfg_err)
);

// File: tb/sclk_reload_timer_bench.sv
module sclk_reload_timer_bench;
   localparam int NV = 6;
   // {master(1), reload(16), half period in edges(17)}
   localparam logic [33:0] VEC [NV] = '{
      {1'b1, 16'h0013, 17'd20},
      {1'b1, 16'h0009, 17'd10},
      {1'b0, 16'h0001, 17'd2},
      {1'b1, 16'h001A, 17'd27},
      {1'b0, 16'h0063, 17'd100},
      {1'b1, 16'hFFFF, 17'd65536}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        master_mode = 1'b1;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        sclk, half_tick, cfg_err;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sclk_reload_timer u_sclk_reload_timer (
      .clk(clk), .rst_n(rst_n), .en(en), .master_mode(master_mode),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sclk(sclk), .half_tick(half_tick), .cfg_err(cfg_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
         summary();
      end
   end

   // counts posedges (sampled at negedge) until half_tick is seen
   task automatic wait_tick(output int n);
      n = 0;
      for (int i = 0; i < 70000; i++) begin
         @(posedge clk); @(negedge clk);
         n++;
         if (half_tick) return;
      end
   endtask

   task automatic wr_reg(input logic [15:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rdata", reg_rdata, 0);
      check("R1 sclk", sclk, 0);
      check("R1 tick", half_tick, 0);
      check("R1 cfg_err", cfg_err, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         master_mode = VEC[v][33];
         wr_reg(VEC[v][32:17]);
         check("R2 readback", reg_rdata, int'(VEC[v][32:17]));
         en = 1'b1;
         wait_tick(n);
         check("R5/R10 first tick", n, int'(VEC[v][16:0]));
         @(posedge clk); @(negedge clk);
         check("R6 sclk high", sclk, 1);
         wait_tick(n);
         check("R5/R10 tick gap", n + 1, int'(VEC[v][16:0]));
         @(posedge clk); @(negedge clk);
         check("R6 sclk low", sclk, 0);
         en = 1'b0;
         @(negedge clk);
      end

      // R3 live counter readback
      master_mode = 1'b1;
      wr_reg(16'd5);
      en = 1'b1;
      @(negedge clk);
      check("R3 loaded", reg_rdata, 5);
      @(negedge clk);
      check("R3 count", reg_rdata, 4);
      // R4 write while enabled ignored
      wr_reg(16'h0077);
      check("R4 count unaffected", reg_rdata, 3);
      wait_tick(n);
      check("R4 tick at zero", n, 3);
      wait_tick(n);
      check("R4 gap unchanged", n, 6);
      en = 1'b0;
      @(negedge clk);
      check("R4 reload kept", reg_rdata, 5);
      // R7 idle
      begin
         int ticks = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (half_tick || sclk) ticks++;
         end
         check("R7 no activity idle", ticks, 0);
      end
      check("R7 reload visible", reg_rdata, 5);

      // R8 master reload zero
      wr_reg(16'd0);
      en = 1'b1;
      wait_tick(n);
      check("R8 first tick", n, 1);
      wait_tick(n);
      check("R8 gap", n, 1);
      check("R8 no err", cfg_err, 0);
      en = 1'b0;
      @(negedge clk);

      // R9 slave reload zero clamps to one
      master_mode = 1'b0;
      en = 1'b1;
      wait_tick(n);
      check("R9 first tick", n, 2);
      wait_tick(n);
      check("R9 gap", n, 2);
      check("R9 err set", cfg_err, 1);
      en = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 err sticky", cfg_err, 1);
      wr_reg(16'd9);
      check("R9 err cleared", cfg_err, 0);

      done = 1'b1;
      summary();
   end
endmodule